// File: doc/BRIEF.md
# I/O Cycle Target Router

This block decides where a processor I/O cycle goes. Each cycle presents a 16-bit port address together with the current bridge settings: a 4-bit window floor, a 4-bit window ceiling, an I/O routing enable, a legacy display enable and a flag that says a monochrome display adapter sits on the legacy side. The block either claims the cycle for the downstream PCI Express port or hands it to the legacy chipset link, which takes every cycle nobody else claims.

The window works at 4 KB granularity. Only address bits [15:12] take part in the comparison, so the floor is read as `floor:000h` and the ceiling as `ceiling:FFFh`. A fixed set of legacy display ports does not use the window at all. Those ports have their own enables, and the monochrome ports have a further override that sends them to the legacy link.

The decision is registered. A request strobe in one cycle produces a response strobe with the chosen target in the next cycle.

Top module: `io_cycle_router`

## Requirements
- R1: While reset is high, and on the first clock after it, `rsp_valid`, `rsp_sel` and `rsp_claim` are all zero.
- R2: `rsp_valid` is high exactly in the cycle after one in which `req_valid` was high. When `rsp_valid` is low, `rsp_sel` and `rsp_claim` are zero.
- R3: For an address that is not a legacy display port, the cycle goes to PCI Express when the I/O enable is set and `cfg_base <= req_addr[15:12] <= cfg_limit`. Both bounds are inclusive, so `base*1000h` and `limit*1000h+FFFh` are both inside the window.
- R4: When `cfg_base > cfg_limit` the window is empty, and no non-legacy address is claimed.
- R5: When `cfg_io_en` is clear, no cycle is sent to PCI Express, whether or not its address lies inside the window.
- R6: The legacy display ports are 3B0h–3BBh and 3C0h–3DFh. They ignore the window and go to PCI Express only when both `cfg_vga_en` and `cfg_io_en` are set. Otherwise they go to the legacy link.
- R7: When `cfg_mono_en` is set, ports 3B4h, 3B5h, 3B8h, 3B9h, 3BAh and 3BFh always go to the legacy link. This override beats the display enable and the window.
- R8: `rsp_sel` is one-hot while `rsp_valid` is high. Bit 0 selects PCI Express and bit 1 selects the legacy link. Any cycle that is not claimed for PCI Express selects the legacy link.
- R9: `rsp_claim` is high exactly when a valid response selects PCI Express.
- R10: Ports in 3BCh–3BFh lie outside the legacy display ranges. Unless R7 applies to them, they follow the window rule of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | An I/O cycle address is present |
| req_addr | input | 16 | Processor I/O port address |
| cfg_base | input | 4 | Window floor, matched against address bits [15:12] |
| cfg_limit | input | 4 | Window ceiling, matched against address bits [15:12] |
| cfg_io_en | input | 1 | Permits routing of I/O cycles to PCI Express |
| cfg_vga_en | input | 1 | Permits legacy display ports to go to PCI Express |
| cfg_mono_en | input | 1 | A monochrome adapter is present on the legacy link |
| rsp_valid | output | 1 | Decision valid, one cycle after `req_valid` |
| rsp_sel | output | 2 | One-hot target: bit 0 PCI Express, bit 1 legacy link |
| rsp_claim | output | 1 | Cycle positively claimed for PCI Express |

## Verification
The bench tries every floor and ceiling pair, including reversed pairs. At each pair it probes the address just below the window, the first address in it, the last address in it and the address just past it. A design that compared the low 12 bits, or that used exclusive bounds, fails on these edge addresses. A reversed pair that still claims something exposes a design that wraps or swaps its bounds.

Every port from 3AFh to 3E0h is swept under all eight enable combinations, once with a window that covers these ports and once with a window that misses them. This catches a display port that leaks through the window, and a monochrome port that the display enable wrongly wins. It also catches a 3BCh–3BFh port that is wrongly handled as a display port.

// File: rtl/io_route_pkg.sv
package io_route_pkg;

    localparam int IO_ADDR_W = 16;
    localparam int IO_NIB_W  = 4;

    // Legacy display port spans (inclusive)
    localparam logic [IO_ADDR_W-1:0] DISP_A_LO = 16'h03B0;
    localparam logic [IO_ADDR_W-1:0] DISP_A_HI = 16'h03BB;
    localparam logic [IO_ADDR_W-1:0] DISP_B_LO = 16'h03C0;
    localparam logic [IO_ADDR_W-1:0] DISP_B_HI = 16'h03DF;

    localparam int MONO_PORTS = 6;
    localparam logic [MONO_PORTS*IO_ADDR_W-1:0] MONO_LIST = {
        16'h03BF, 16'h03BA, 16'h03B9, 16'h03B8, 16'h03B5, 16'h03B4
    };

    typedef enum logic [1:0] {
        TGT_NONE = 2'b00,
        TGT_PCIE = 2'b01,
        TGT_LINK = 2'b10
    } io_target_e;

    typedef struct packed {
        logic [IO_NIB_W-1:0] base;
        logic [IO_NIB_W-1:0] limit;
        logic                io_en;
        logic                vga_en;
        logic                mono_en;
    } io_cfg_t;

    typedef struct packed {
        logic win_hit;
        logic disp_port;
        logic mono_port;
    } io_class_t;

    typedef struct packed {
        logic       valid;
        io_target_e target;
        logic       claim;
    } io_result_t;

    function automatic logic in_span(input logic [IO_ADDR_W-1:0] a,
                                     input logic [IO_ADDR_W-1:0] lo,
                                     input logic [IO_ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/io_window_match.sv
module io_window_match
    import io_route_pkg::*;
#(
    parameter int NIB_W = IO_NIB_W
) (
    input  logic [NIB_W-1:0] addr_nib,
    input  logic [NIB_W-1:0] floor_nib,
    input  logic [NIB_W-1:0] ceil_nib,
    output logic             hit
);
    // Low bits are implied 0 for the floor and all-ones for the ceiling,
    // so only the top nibble needs comparing; a reversed pair never hits.
    logic above_floor;
    logic below_ceil;

    always_comb begin
        above_floor = (addr_nib >= floor_nib);
        below_ceil  = (addr_nib <= ceil_nib);
        hit         = above_floor && below_ceil;
    end
endmodule

// File: rtl/io_legacy_classify.sv
module io_legacy_classify
    import io_route_pkg::*;
#(
    parameter int ADDR_W = IO_ADDR_W,
    parameter int N_MONO = MONO_PORTS
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              disp_port,
    output logic              mono_port
);
    logic [N_MONO-1:0] mono_eq;

    for (genvar g = 0; g < N_MONO; g++) begin : g_mono
        assign mono_eq[g] = (addr == ADDR_W'(MONO_LIST[g*IO_ADDR_W +: IO_ADDR_W]));
    end

    always_comb begin
        disp_port = in_span(IO_ADDR_W'(addr), DISP_A_LO, DISP_A_HI)
                 || in_span(IO_ADDR_W'(addr), DISP_B_LO, DISP_B_HI);
        mono_port = |mono_eq;
    end
endmodule

// File: rtl/io_route_select.sv
module io_route_select
    import io_route_pkg::*;
(
    input  io_class_t  cls,
    input  io_cfg_t    cfg,
    output io_target_e target
);
    always_comb begin
        if (cls.mono_port && cfg.mono_en) begin
            target = TGT_LINK;
        end else if (cls.disp_port) begin
            target = (cfg.vga_en && cfg.io_en) ? TGT_PCIE : TGT_LINK;
        end else begin
            target = (cls.win_hit && cfg.io_en) ? TGT_PCIE : TGT_LINK;
        end
    end
endmodule

// File: rtl/io_cycle_router.sv
module io_cycle_router
    import io_route_pkg::*;
#(
    parameter int ADDR_W = IO_ADDR_W,
    parameter int NIB_W  = IO_NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NIB_W-1:0]  cfg_base,
    input  logic [NIB_W-1:0]  cfg_limit,
    input  logic              cfg_io_en,
    input  logic              cfg_vga_en,
    input  logic              cfg_mono_en,
    output logic              rsp_valid,
    output logic [1:0]        rsp_sel,
    output logic              rsp_claim
);
    localparam int NIB_LSB = ADDR_W - NIB_W;

    io_cfg_t    cfg;
    io_class_t  cls;
    io_target_e next_tgt;
    io_result_t res_q;

    assign cfg = '{base: cfg_base, limit: cfg_limit, io_en: cfg_io_en,
                   vga_en: cfg_vga_en, mono_en: cfg_mono_en};

    io_window_match #(.NIB_W(NIB_W)) u_win (
        .addr_nib  (req_addr[ADDR_W-1:NIB_LSB]),
        .floor_nib (cfg_base),
        .ceil_nib  (cfg_limit),
        .hit       (cls.win_hit)
    );

    io_legacy_classify #(.ADDR_W(ADDR_W)) u_legacy (
        .addr      (req_addr),
        .disp_port (cls.disp_port),
        .mono_port (cls.mono_port)
    );

    io_route_select u_sel (
        .cls    (cls),
        .cfg    (cfg),
        .target (next_tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '{valid: 1'b0, target: TGT_NONE, claim: 1'b0};
        end else if (req_valid) begin
            res_q <= '{valid: 1'b1, target: next_tgt, claim: (next_tgt == TGT_PCIE)};
        end else begin
            res_q <= '{valid: 1'b0, target: TGT_NONE, claim: 1'b0};
        end
    end

    assign rsp_valid = res_q.valid;
    assign rsp_sel   = res_q.target;
    assign rsp_claim = res_q.claim;
endmodule

// File: rtl/io_cycle_router_chk.sv
module io_cycle_router_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [15:0] req_addr,
    input logic [3:0]  cfg_base,
    input logic [3:0]  cfg_limit,
    input logic        cfg_io_en,
    input logic        cfg_vga_en,
    input logic        cfg_mono_en,
    input logic        rsp_valid,
    input logic [1:0]  rsp_sel,
    input logic        rsp_claim
);
    logic mono_hit;
    assign mono_hit = req_addr inside {16'h03B4, 16'h03B5, 16'h03B8,
                                       16'h03B9, 16'h03BA, 16'h03BF};

    p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_no_resp_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && rsp_sel == 2'b00 && !rsp_claim));
    p_sel_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones(rsp_sel) == 1);
    p_claim_is_pcie_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_claim |-> (rsp_valid && rsp_sel == 2'b01));
    p_io_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cfg_io_en) |=> (!rsp_claim && rsp_sel == 2'b10));
    p_empty_window_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cfg_base > cfg_limit && !cfg_vga_en) |=> !rsp_claim);
    p_mono_override_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cfg_mono_en && mono_hit) |=> rsp_sel == 2'b10);
endmodule

bind io_cycle_router io_cycle_router_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .cfg_base    (cfg_base),
    .cfg_limit   (cfg_limit),
    .cfg_io_en   (cfg_io_en),
    .cfg_vga_en  (cfg_vga_en),
    .cfg_mono_en (cfg_mono_en),
    .rsp_valid   (rsp_valid),
    .rsp_sel     (rsp_sel),
    .rsp_claim   (rsp_claim)
);

// File: tb/io_cycle_router_test.sv
`timescale 1ns/1ps
module io_cycle_router_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [15:0] req_addr;
    logic [3:0]  cfg_base;
    logic [3:0]  cfg_limit;
    logic        cfg_io_en;
    logic        cfg_vga_en;
    logic        cfg_mono_en;
    logic        rsp_valid;
    logic [1:0]  rsp_sel;
    logic        rsp_claim;

    int errors = 0;
    int checks = 0;
    int exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    io_cycle_router uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_io_en(cfg_io_en),
        .cfg_vga_en(cfg_vga_en), .cfg_mono_en(cfg_mono_en),
        .rsp_valid(rsp_valid), .rsp_sel(rsp_sel), .rsp_claim(rsp_claim)
    );

    function automatic void check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    // Behavioural reference: returns 1 for PCI Express, 0 for legacy link
    function automatic int goes_pcie(int a, int b, int l, bit io, bit vga, bit mono,
                                     output string why);
        bit is_mono = (a == 'h3B4 || a == 'h3B5 || a == 'h3B8 ||
                       a == 'h3B9 || a == 'h3BA || a == 'h3BF);
        bit is_disp = (a >= 'h3B0 && a <= 'h3BB) || (a >= 'h3C0 && a <= 'h3DF);
        int lo = b * 4096;
        int hi = l * 4096 + 4095;
        if (mono && is_mono) begin why = "R7"; return 0; end
        if (is_disp) begin why = "R6"; return (vga && io) ? 1 : 0; end
        if (!io) why = "R5";
        else if (b > l) why = "R4";
        else if (a >= 'h3BC && a <= 'h3BF) why = "R10";
        else why = "R3";
        return (io && a >= lo && a <= hi) ? 1 : 0;
    endfunction

    // Compare last cycle's expectation, then drive this cycle's request
    task automatic step(bit v, int a, int b, int l, bit io, bit vga, bit mono);
        string why;
        int p;
        int e;
        @(negedge clk);
        e = exp_q.pop_front();
        why = tag_q.pop_front();
        check("R2 valid", int'(rsp_valid), e >> 2);
        check({why, " R8 sel"}, int'(rsp_sel), e & 3);
        check("R9 claim", int'(rsp_claim), (e & 3) == 1 ? 1 : 0);
        req_valid   = v;
        req_addr    = a[15:0];
        cfg_base    = b[3:0];
        cfg_limit   = l[3:0];
        cfg_io_en   = io;
        cfg_vga_en  = vga;
        cfg_mono_en = mono;
        if (v) begin
            p = goes_pcie(a, b, l, io, vga, mono, why);
            exp_q.push_back(4 | (p ? 1 : 2));
        end else begin
            why = "R2";
            exp_q.push_back(0);
        end
        tag_q.push_back(why);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b1; req_addr = 16'h1000;
        cfg_base = 4'h0; cfg_limit = 4'hF;
        cfg_io_en = 1'b1; cfg_vga_en = 1'b1; cfg_mono_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", int'(rsp_valid), 0);
        check("R1 reset sel", int'(rsp_sel), 0);
        check("R1 reset claim", int'(rsp_claim), 0);
        rst = 1'b0; req_valid = 1'b0;
        exp_q.push_back(0); tag_q.push_back("R1");

        // Idle cycles (R2)
        step(0, 'h1000, 0, 15, 1, 1, 0);
        step(0, 'h1000, 0, 15, 1, 1, 0);

        // Window boundaries for every floor/ceiling pair (R3, R4)
        for (int b = 0; b < 16; b++) begin
            for (int l = 0; l < 16; l++) begin
                step(1, b * 4096, b, l, 1, 0, 0);
                if (b > 0) step(1, b * 4096 - 1, b, l, 1, 0, 0);
                step(1, l * 4096 + 4095, b, l, 1, 0, 0);
                if (l < 15) step(1, l * 4096 + 4096, b, l, 1, 0, 0);
            end
        end

        // I/O enable clear inside an open window (R5)
        for (int b = 0; b < 16; b++) begin
            step(1, b * 4096 + 'h123, 0, 15, 0, 1, 0);
            step(1, b * 4096, b, b, 0, 0, 1);
        end

        // Legacy port sweep under all enable combinations (R6, R7, R10)
        for (int w = 0; w < 2; w++) begin
            for (int en = 0; en < 8; en++) begin
                for (int a = 'h3AF; a <= 'h3E0; a++) begin
                    step(1, a, w ? 1 : 0, w ? 15 : 0,
                         en[0], en[1], en[2]);
                end
                step(0, 0, 0, 0, 0, 0, 0);
            end
        end

        step(0, 0, 0, 0, 0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule